// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps a free-running 32-bit count of seconds behind a simple APB-style register bus. A prescaler divides the system clock down to one step per second, and software can load the count with a new value. A separate compare register raises an alarm when the count steps onto the programmed value. Because comparison is by equality on a counter that wraps, a compare value below the current count fires only after the count has wrapped past all ones.

The alarm sets a raw status bit. A one-bit mask gates it onto a level interrupt line. Software reads the raw and the masked status at separate offsets and clears the alarm by writing anything to the clear offset. The peripheral occupies a 4 KB window. Eight identification bytes sit at its top, one byte in the low bits of each word. The control word is hard-wired: it always reads as enabled.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset, the count, compare value, mask and raw status all read zero, and `irq` is low.
- R2: The count (offset 0x00) grows by one every CLKS_PER_SEC clock cycles. It wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x08 sets the count to the written data and restarts the prescaler, so the next step comes exactly CLKS_PER_SEC cycles after the write. Offset 0x08 reads back the last written data, not the live count.
- R4: The raw status (bit 0 of offset 0x14) sets in the cycle the count steps onto the compare value (offset 0x04, which reads back as written), including a step that follows a wrap. A load does not set it.
- R5: `irq` and bit 0 of offset 0x18 both equal raw status AND mask. The mask is bit 0 of offset 0x10, and only that bit is stored.
- R6: Any write to offset 0x1C clears the raw status, whatever the data. If a match step falls in the same cycle, the raw status stays set.
- R7: Offset 0x0C always reads 1, and writes to it change nothing.
- R8: Offsets 0xFE0, 0xFE4, ... 0xFFC read the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order, in bits 7:0.
- R9: Any other offset reads zero, and writes to it are ignored.
- R10: Read data is captured in the setup phase and is valid in the access phase. Writes take effect at the access-phase edge. There are no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, raw status AND mask |

## Verification
A clear write and the count stepping onto the compare value can land on the same edge. The bench provokes this by loading the count to one below the compare value and then placing a clear write so its access edge falls exactly CLKS_PER_SEC cycles after the load. It expects the raw status to remain set afterwards. A second run moves the clear one cycle later and expects the status to read zero, which shows the ordering rule rather than a clear that was simply lost.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_MATCH = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_MSKD  = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h01C;

  // upper address bits that select the identification words
  localparam logic [6:0] ID_PAGE = 7'h7F;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CLKS_PER_SEC = 250_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_SEC - 1);

  logic [PW-1:0] psc_q;

  assign tick = (psc_q == LAST) && !restart;

  always_ff @(posedge clk) begin
    if (rst)                  psc_q <= '0;
    else if (restart || tick) psc_q <= '0;
    else                      psc_q <= psc_q + 1'b1;
  end

  // R2: the divider never runs past its terminal count
  p_psc_range_r2: assert property (@(posedge clk) disable iff (rst)
    psc_q <= LAST);
  // R3: a restart brings the divider back to zero
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    restart |=> (psc_q == '0));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] count_q,
  output logic             hit
);
  logic [CNT_W-1:0] count_inc;

  assign count_inc = count_q + 1'b1;
  // a match is the step onto the compare value, never a load
  assign hit = tick && !load_en && (count_inc == match_val);

  always_ff @(posedge clk) begin
    if (rst)          count_q <= '0;
    else if (load_en) count_q <= load_val;
    else if (tick)    count_q <= count_inc;
  end

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_en) |=> (count_q == $past(count_q) + 1'b1));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_en) |=> $stable(count_q));
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (count_q == $past(load_val)));
  p_hit_lands_r4: assert property (@(posedge clk) disable iff (rst)
    hit |=> (count_q == $past(match_val)));
endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
  import rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              hit,
  output logic              load_en,
  output logic [CNT_W-1:0]  load_q,
  output logic [CNT_W-1:0]  match_q,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);
  logic wr_acc, rd_setup, clr_en, mask_en;
  logic mask_q, raw_q, mask_d, raw_d;
  logic [DATA_W-1:0] rd_mux;

  assign wr_acc   = psel && penable && pwrite;
  assign rd_setup = psel && !penable && !pwrite;
  assign load_en  = wr_acc && (paddr == OFF_LOAD);
  assign clr_en   = wr_acc && (paddr == OFF_CLR);
  assign mask_en  = wr_acc && (paddr == OFF_MASK);

  // a match in the clearing cycle keeps the alarm pending
  always_comb begin
    raw_d  = hit ? 1'b1 : (clr_en ? 1'b0 : raw_q);
    mask_d = mask_en ? pwdata[0] : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= '0;
      match_q <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (load_en) load_q <= CNT_W'(pwdata);
      if (wr_acc && (paddr == OFF_MATCH)) match_q <= CNT_W'(pwdata);
      mask_q <= mask_d;
      raw_q  <= raw_d;
      irq    <= raw_d & mask_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (paddr)
      OFF_COUNT: rd_mux = DATA_W'(count);
      OFF_MATCH: rd_mux = DATA_W'(match_q);
      OFF_LOAD:  rd_mux = DATA_W'(load_q);
      OFF_CTRL:  rd_mux = DATA_W'(1);
      OFF_MASK:  rd_mux = DATA_W'(mask_q);
      OFF_RAW:   rd_mux = DATA_W'(raw_q);
      OFF_MSKD:  rd_mux = DATA_W'(raw_q & mask_q);
      default: begin
        if (paddr[ADDR_W-1:5] == ID_PAGE && paddr[1:0] == 2'b00)
          rd_mux = DATA_W'(id_byte(paddr[4:2]));
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_mux;
  end

  p_irq_and_r5: assert property (@(posedge clk) disable iff (rst)
    irq == (raw_q & mask_q));
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    hit |=> raw_q);
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !hit) |=> !raw_q);
  p_ctrl_one_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && paddr == OFF_CTRL) |=> (prdata == DATA_W'(1)));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_setup |=> $stable(prdata));
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_pkg::*;
#(
  parameter int CLKS_PER_SEC = 250_000_000,
  parameter int CNT_W        = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);
  logic             tick, load_en, hit;
  logic [CNT_W-1:0] count, load_q, match_q;

  rtc_prescaler #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_psc (
    .clk(clk), .rst(rst), .restart(load_en), .tick(tick)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load_en(load_en),
    .load_val(CNT_W'(pwdata)), .match_val(match_q),
    .count_q(count), .hit(hit)
  );

  rtc_bus_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .count(count), .hit(hit), .load_en(load_en), .load_q(load_q),
    .match_q(match_q), .prdata(prdata), .irq(irq)
  );
endmodule

// File: tb/rtc_alarm_top_tb_top.sv
module rtc_alarm_top_tb_top;
  localparam int CPS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rtc_alarm_top #(.CLKS_PER_SEC(CPS), .CNT_W(32)) dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); d = prdata; psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(12'h000, v); check("R1 count", v, 32'd0);
    rd(12'h004, v); check("R1 match", v, 32'd0);
    rd(12'h010, v); check("R1 mask", v, 32'd0);
    rd(12'h014, v); check("R1 raw", v, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(12'h004, 32'h8000_0000);
    rd(12'h004, v); check("R4 match readback", v, 32'h8000_0000);
    wr(12'h00C, 32'h0);
    rd(12'h00C, v); check("R7 ctrl reads one", v, 32'd1);
    wr(12'h010, 32'hFFFF_FFFE);
    rd(12'h010, v); check("R5 mask only bit0", v, 32'd0);
    wr(12'h020, 32'hDEAD_BEEF);
    rd(12'h020, v); check("R9 unlisted reads zero", v, 32'd0);
    rd(12'h004, v); check("R9 unlisted write ignored", v, 32'h8000_0000);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      case (i)
        0: e = 8'h31; 1: e = 8'h10; 2: e = 8'h14; 3: e = 8'h00;
        4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
      endcase
      rd(12'hFE0 + 12'(4 * i), v); check("R8 id byte", v, {24'd0, e});
    end
  endtask

  task automatic t_load_step();
    logic [31:0] v;
    wr(12'h008, 32'd5000);
    rd(12'h000, v); check("R3 load takes effect (R10)", v, 32'd5000);
    idle(3 * CPS + 2);
    rd(12'h000, v); check("R2 three steps", v, 32'd5003);
    rd(12'h008, v); check("R3 load reads written value", v, 32'd5000);
    idle(5);
    wr(12'h008, 32'd7000);
    idle(CPS - 2);
    rd(12'h000, v); check("R3 no early step", v, 32'd7000);
    wr(12'h008, 32'd7000);
    idle(CPS - 1);
    rd(12'h000, v); check("R3 step one period later", v, 32'd7001);
  endtask

  task automatic t_alarm_mask();
    logic [31:0] v;
    wr(12'h010, 32'd0);
    wr(12'h004, 32'd102);
    wr(12'h008, 32'd100);
    idle(CPS + 2);
    rd(12'h014, v); check("R4 raw not yet", v, 32'd0);
    idle(CPS);
    rd(12'h014, v); check("R4 raw set at match", v, 32'd1);
    rd(12'h018, v); check("R5 masked zero", v, 32'd0);
    check("R5 irq masked", {31'd0, irq}, 32'd0);
    wr(12'h010, 32'd1);
    check("R5 irq on unmask", {31'd0, irq}, 32'd1);
    rd(12'h018, v); check("R5 masked one", v, 32'd1);
    wr(12'h1C, 32'd0);
    check("R6 clear any data irq", {31'd0, irq}, 32'd0);
    rd(12'h014, v); check("R6 raw cleared", v, 32'd0);
    wr(12'h008, 32'd102);
    idle(3);
    rd(12'h014, v); check("R4 load onto match no alarm", v, 32'd0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(12'h004, 32'd1);
    wr(12'h008, 32'hFFFF_FFFE);
    idle(CPS + 4);
    check("R4 no alarm before wrap", {31'd0, irq}, 32'd0);
    idle(2 * CPS);
    rd(12'h000, v); check("R2 wrapped count", v, 32'd1);
    check("R4 alarm after wrap", {31'd0, irq}, 32'd1);
    wr(12'h01C, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(12'h004, 32'd301);
    wr(12'h008, 32'd300);
    idle(CPS - 3);
    wr(12'h01C, 32'd0);   // access edge coincides with the match step
    rd(12'h014, v); check("R6 set wins over clear", v, 32'd1);
    wr(12'h01C, 32'd0);
    wr(12'h004, 32'd401);
    wr(12'h008, 32'd400);
    idle(CPS - 2);
    wr(12'h01C, 32'd0);   // one cycle after the match step
    rd(12'h014, v); check("R6 later clear wins", v, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_regs();
    t_load_step();
    t_alarm_mask();
    t_wrap();
    t_collide();
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule